// File: doc/BRIEF.md
# Multi-Channel Dual-Compare Interval Timer

This block holds a small bank of independent 16-bit up-counters. Each channel has two compare registers (A and B), a mode byte and a compare-enable byte. Each channel counts on a per-channel tick while its run bit is set. When the incremented count equals an enabled compare register, the block records a flag. The channel then either restarts from zero (when that compare is the channel's selected clear source) or halts with the matched value held. A channel with both compares disabled instead flags counter wrap-around.

Software reaches every register through one byte-wide port. Writes take effect on the clock edge and reads are combinational from the address. Three shared status registers (compare A, compare B, wrap) each hold one flag bit and one interrupt-enable bit per channel. Each flag and enable pair drives its own level interrupt line.

Top module: `tmr_bank`

## Requirements
- R1: After reset every register reads 0x00 and every interrupt line is low.
- R2: While run bit n (bit n of address 0x60) is 1 and tick[n] is high, channel n's counter increments by one per clock, wrapping from 0xFFFF to 0x0000. With the tick low or the run bit 0, the counter holds.
- R3: Each channel n has an 8-byte window at 0x68+8n: mode at offset 0, compare-enable at 1, counter high/low at 2/3, compare A high/low at 4/5, compare B high/low at 6/7. Every byte reads back what was written. Addresses outside the map read 0x00.
- R4: Compare A is active when compare-enable bits [1:0] are not 00, and compare B when bits [5:4] are not 00. A match is an active compare equal to the incremented count; it sets bit n of 0x64 (A) or 0x65 (B) one clock later.
- R5: Mode bits [6:5] = 01 make a compare-A match clear the counter, and 10 make a compare-B match clear it. The counter becomes 0x0000 and the run bit stays 1.
- R6: A match on a compare that is not the selected clear source leaves the incremented value in the counter and clears run bit n, so the channel stops until software sets the bit again. This clear wins over a same-cycle software write of that bit.
- R7: When compare-enable bits under mask 0x33 are all zero and an increment wraps the counter to 0x0000, bit n of 0x66 is set.
- R8: In 0x64 to 0x66, bits [2:0] are per-channel flags and bits [6:4] are per-channel interrupt enables. Writing 0 to a flag bit clears it and writing 1 leaves it unchanged. A hardware set in the same cycle wins over the clear.
- R9: irq[3n] (A), irq[3n+1] (B) and irq[3n+2] (wrap) are high exactly while the matching flag bit n and enable bit n+4 are both 1.
- R10: A software write to a counter byte in the same cycle as a tick loads that byte and suppresses the increment and match checks for that cycle.
- R11: With both compares inactive, an incremented count equal to a compare register's value sets no flag and does not stop the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Write strobe for reg_wdata at reg_addr |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| tick | input | 3 | Per-channel count enable |
| irq | output | 9 | Per-channel level interrupt requests, three per channel |

## Verification
A corrupted counter shows up at the port as a wrong byte the next time software reads that window. It also shows up as a match flag that rises early, late or never, one clock after the increment that should hit. A run bit that is wrongly left set or wrongly cleared is visible as a channel that keeps counting past a stop point or freezes. That shows within the next tick, in the counter and in 0x60. A bad flag or enable bit appears on the irq lines in the very next cycle, so the bench compares all nine lines against its model on every step.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W   = 8;
  localparam int CNT_W    = 16;
  localparam int WIN_SIZE = 8;
  localparam logic [7:0] RUN_ADDR  = 8'h60;
  localparam logic [7:0] STA_ADDR  = 8'h64;
  localparam logic [7:0] STB_ADDR  = 8'h65;
  localparam logic [7:0] STO_ADDR  = 8'h66;
  localparam logic [7:0] WIN_BASE  = 8'h68;
  localparam int EN_LSB = 4;

  typedef enum logic [2:0] {
    OFF_MODE = 3'd0, OFF_CEN = 3'd1, OFF_CNTH = 3'd2, OFF_CNTL = 3'd3,
    OFF_CAH  = 3'd4, OFF_CAL = 3'd5, OFF_CBH  = 3'd6, OFF_CBL  = 3'd7
  } win_off_e;

  typedef enum logic [1:0] {
    CLR_NONE = 2'b00, CLR_ON_A = 2'b01, CLR_ON_B = 2'b10, CLR_RSVD = 2'b11
  } clr_sel_e;

  function automatic logic [CNT_W-1:0] cnt_next(input logic [CNT_W-1:0] c);
    return c + 1'b1;
  endfunction

  function automatic logic cmp_hit(input logic active,
                                   input logic [CNT_W-1:0] nxt,
                                   input logic [CNT_W-1:0] ref_val);
    return active && (nxt == ref_val);
  endfunction

  function automatic logic in_window(input logic [7:0] a, input int nch);
    return (a >= WIN_BASE) && (int'(a - WIN_BASE) < nch * WIN_SIZE);
  endfunction

  function automatic int win_chan(input logic [7:0] a);
    return int'(a - WIN_BASE) / WIN_SIZE;
  endfunction

  function automatic logic [2:0] win_off(input logic [7:0] a);
    logic [7:0] d;
    d = a - WIN_BASE;
    return d[2:0];
  endfunction
endpackage

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_off,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [2:0]       rd_off,
  output logic [BYTE_W-1:0] rd_data,
  input  logic             tick,
  input  logic             run,
  output logic             ev_a,
  output logic             ev_b,
  output logic             ev_ovf,
  output logic             halt
);
  logic [BYTE_W-1:0] mode_q, cen_q;
  logic [CNT_W-1:0]  cnt_q, cmpa_q, cmpb_q;
  logic [CNT_W-1:0]  nxt;
  logic              a_on, b_on, cnt_wr, step, clr_hit;
  clr_sel_e          clr_sel;

  assign nxt     = cnt_next(cnt_q);
  assign a_on    = |cen_q[1:0];
  assign b_on    = |cen_q[5:4];
  assign clr_sel = clr_sel_e'(mode_q[6:5]);
  assign cnt_wr  = wr_en && (wr_off == OFF_CNTH || wr_off == OFF_CNTL);
  assign step    = tick && run && !cnt_wr;
  assign ev_a    = step && cmp_hit(a_on, nxt, cmpa_q);
  assign ev_b    = step && cmp_hit(b_on, nxt, cmpb_q);
  assign ev_ovf  = step && ((cen_q & 8'h33) == 8'h00) && (nxt == '0);
  assign clr_hit = (ev_a && clr_sel == CLR_ON_A) || (ev_b && clr_sel == CLR_ON_B);
  assign halt    = (ev_a && clr_sel != CLR_ON_A) || (ev_b && clr_sel != CLR_ON_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      cen_q  <= '0;
      cnt_q  <= '0;
      cmpa_q <= '0;
      cmpb_q <= '0;
    end else begin
      if (wr_en) begin
        case (wr_off)
          OFF_MODE: mode_q       <= wr_data;
          OFF_CEN:  cen_q        <= wr_data;
          OFF_CNTH: cnt_q[15:8]  <= wr_data;
          OFF_CNTL: cnt_q[7:0]   <= wr_data;
          OFF_CAH:  cmpa_q[15:8] <= wr_data;
          OFF_CAL:  cmpa_q[7:0]  <= wr_data;
          OFF_CBH:  cmpb_q[15:8] <= wr_data;
          default:  cmpb_q[7:0]  <= wr_data;
        endcase
      end
      if (step) cnt_q <= clr_hit ? '0 : nxt;
    end
  end

  always_comb begin
    case (rd_off)
      OFF_MODE: rd_data = mode_q;
      OFF_CEN:  rd_data = cen_q;
      OFF_CNTH: rd_data = cnt_q[15:8];
      OFF_CNTL: rd_data = cnt_q[7:0];
      OFF_CAH:  rd_data = cmpa_q[15:8];
      OFF_CAL:  rd_data = cmpa_q[7:0];
      OFF_CBH:  rd_data = cmpb_q[15:8];
      default:  rd_data = cmpb_q[7:0];
    endcase
  end

  // R2: no tick, no run or a software load -> no counting
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(tick && run) && !wr_en) |=> $stable(cnt_q));
  // R2: plain increment
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr_hit) |=> (cnt_q == $past(cnt_q) + 16'd1));
  // R5: selected match restarts from zero
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> (cnt_q == '0));
  // R7: wrap event leaves counter at zero
  p_ovf_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovf |=> (cnt_q == '0));
  // R10: low-byte load beats a tick
  p_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_off == OFF_CNTL) |=> (cnt_q[7:0] == $past(wr_data)));
  // R11: inactive compares produce no events
  p_no_ev_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_on && !b_on) |-> (!ev_a && !ev_b && !halt));
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags
  import tmr_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [NCH-1:0]    ev,
  output logic [BYTE_W-1:0] rd_data,
  output logic [NCH-1:0]    irq
);
  logic [NCH-1:0] flag_q, en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
    end else begin
      if (wr_en) en_q <= wr_data[EN_LSB +: NCH];
      for (int n = 0; n < NCH; n++) begin
        if (ev[n])                       flag_q[n] <= 1'b1;
        else if (wr_en && !wr_data[n])   flag_q[n] <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    rd_data[NCH-1:0]         = flag_q;
    rd_data[EN_LSB +: NCH]   = en_q;
  end

  assign irq = flag_q & en_q;

  // R4: hardware event is visible one clock later
  p_flag_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev[0] |=> rd_data[0]);
  // R8: a flag only falls through a software write of 0
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[0] && !(wr_en && !wr_data[0])) |=> rd_data[0]);
  // R9: a request line rises only with its enable set
  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq[0]) |-> rd_data[EN_LSB]);
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic [NCH-1:0]   tick,
  output logic [3*NCH-1:0] irq
);
  localparam int NSTAT = 3;

  logic [NCH-1:0] run_q, halt, ev_a, ev_b, ev_ovf;
  logic [7:0]     ch_rd [NCH];
  logic [7:0]     st_rd [NSTAT];
  logic [NCH-1:0] st_irq [NSTAT];
  logic [NCH-1:0] st_ev [NSTAT];
  logic           win_hit;
  int             win_n;
  logic [2:0]     off;

  initial begin
    if (NCH < 1 || NCH > 4) $error("tmr_bank: NCH must be 1..4");
  end

  assign win_hit = in_window(reg_addr, NCH);
  assign win_n   = win_chan(reg_addr);
  assign off     = win_off(reg_addr);

  generate
    for (genvar n = 0; n < NCH; n++) begin : g_ch
      tmr_channel u_ch (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr && win_hit && win_n == n),
        .wr_off(off), .wr_data(reg_wdata),
        .rd_off(off), .rd_data(ch_rd[n]),
        .tick(tick[n]), .run(run_q[n]),
        .ev_a(ev_a[n]), .ev_b(ev_b[n]), .ev_ovf(ev_ovf[n]),
        .halt(halt[n])
      );
      assign irq[3*n]   = st_irq[0][n];
      assign irq[3*n+1] = st_irq[1][n];
      assign irq[3*n+2] = st_irq[2][n];

      // R6: a non-clearing match stops the channel
      p_halt_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        halt[n] |=> !run_q[n]);
    end
  endgenerate

  assign st_ev[0] = ev_a;
  assign st_ev[1] = ev_b;
  assign st_ev[2] = ev_ovf;

  generate
    for (genvar k = 0; k < NSTAT; k++) begin : g_st
      tmr_flags #(.NCH(NCH)) u_st (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr && reg_addr == STA_ADDR + 8'(k)),
        .wr_data(reg_wdata), .ev(st_ev[k]),
        .rd_data(st_rd[k]), .irq(st_irq[k])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else begin
      if (reg_wr && reg_addr == RUN_ADDR) run_q <= reg_wdata[NCH-1:0];
      for (int n = 0; n < NCH; n++)
        if (halt[n]) run_q[n] <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == RUN_ADDR)      reg_rdata[NCH-1:0] = run_q;
    else if (reg_addr == STA_ADDR) reg_rdata = st_rd[0];
    else if (reg_addr == STB_ADDR) reg_rdata = st_rd[1];
    else if (reg_addr == STO_ADDR) reg_rdata = st_rd[2];
    else if (win_hit) begin
      for (int n = 0; n < NCH; n++)
        if (win_n == n) reg_rdata = ch_rd[n];
    end
  end

  // R1: nothing requests service straight out of reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (irq == '0));
endmodule

// File: tb/tmr_bank_bench.sv
module tmr_bank_bench;
  localparam int NCH = 3;
  logic clk = 0, rst_n = 0;
  logic [7:0] reg_addr = 0, reg_wdata = 0;
  logic reg_wr = 0;
  logic [NCH-1:0] tick = 0;
  logic [7:0] reg_rdata;
  logic [3*NCH-1:0] irq;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0]  m_mode [NCH], m_cen [NCH];
  logic [15:0] m_cnt [NCH], m_ca [NCH], m_cb [NCH];
  logic [7:0]  m_st [3];
  logic [NCH-1:0] m_run;

  always #5 clk = ~clk;

  tmr_bank #(.NCH(NCH)) u_tmr_bank (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] m_read(input logic [7:0] a);
    int n; int o;
    if (a == 8'h60) return {5'b0, m_run};
    if (a >= 8'h64 && a <= 8'h66) return m_st[a - 8'h64];
    if (a >= 8'h68 && a < 8'h68 + 8*NCH) begin
      n = (a - 8'h68) >> 3; o = (a - 8'h68) & 7;
      case (o)
        0: return m_mode[n];  1: return m_cen[n];
        2: return m_cnt[n][15:8]; 3: return m_cnt[n][7:0];
        4: return m_ca[n][15:8];  5: return m_ca[n][7:0];
        6: return m_cb[n][15:8];  default: return m_cb[n][7:0];
      endcase
    end
    return 8'h00;
  endfunction

  function automatic logic [3*NCH-1:0] m_irq();
    logic [3*NCH-1:0] r;
    for (int n = 0; n < NCH; n++)
      for (int k = 0; k < 3; k++)
        r[3*n+k] = m_st[k][n] & m_st[k][n+4];
    return r;
  endfunction

  task automatic m_step(input logic wr, input logic [7:0] a, input logic [7:0] d,
                        input logic [NCH-1:0] tk);
    logic [NCH-1:0] go, ha, hb, ov, stop, zero;
    logic [15:0] inc [NCH];
    for (int n = 0; n < NCH; n++) begin
      logic loaded;
      loaded = wr && (a == 8'h68 + 8*n + 2 || a == 8'h68 + 8*n + 3);
      go[n]  = tk[n] && m_run[n] && !loaded;
      inc[n] = m_cnt[n] + 16'd1;
      ha[n]  = go[n] && (m_cen[n][1:0] != 0) && inc[n] == m_ca[n];
      hb[n]  = go[n] && (m_cen[n][5:4] != 0) && inc[n] == m_cb[n];
      ov[n]  = go[n] && (m_cen[n] & 8'h33) == 0 && inc[n] == 16'h0;
      zero[n] = (ha[n] && m_mode[n][6:5] == 2'b01) || (hb[n] && m_mode[n][6:5] == 2'b10);
      stop[n] = (ha[n] && m_mode[n][6:5] != 2'b01) || (hb[n] && m_mode[n][6:5] != 2'b10);
    end
    if (wr) begin
      if (a == 8'h60) m_run = d[NCH-1:0];
      else if (a >= 8'h64 && a <= 8'h66)
        m_st[a - 8'h64] = (m_st[a - 8'h64] & d & 8'h07) | (d & 8'h70);
      else if (a >= 8'h68 && a < 8'h68 + 8*NCH) begin
        int n; n = (a - 8'h68) >> 3;
        case ((a - 8'h68) & 7)
          0: m_mode[n] = d; 1: m_cen[n] = d;
          2: m_cnt[n][15:8] = d; 3: m_cnt[n][7:0] = d;
          4: m_ca[n][15:8] = d;  5: m_ca[n][7:0] = d;
          6: m_cb[n][15:8] = d;  default: m_cb[n][7:0] = d;
        endcase
      end
    end
    for (int n = 0; n < NCH; n++) begin
      if (ha[n]) m_st[0][n] = 1'b1;
      if (hb[n]) m_st[1][n] = 1'b1;
      if (ov[n]) m_st[2][n] = 1'b1;
      if (go[n]) m_cnt[n] = zero[n] ? 16'h0 : inc[n];
      if (stop[n]) m_run[n] = 1'b0;
    end
  endtask

  task automatic cyc(input logic wr, input logic [7:0] a, input logic [7:0] d,
                     input logic [NCH-1:0] tk);
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = d; tick = tk;
    @(posedge clk);
    m_step(wr, a, d, tk);
    @(negedge clk);
    reg_wr = 0; tick = 0;
    #1;
    chk("R9 irq lines", irq, m_irq());
  endtask

  task automatic wr8(input logic [7:0] a, input logic [7:0] d);
    cyc(1'b1, a, d, '0);
  endtask

  task automatic wr16(input logic [7:0] a, input logic [15:0] v);
    wr8(a, v[15:8]); wr8(a + 8'd1, v[7:0]);
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_wr = 0; tick = 0; reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic rchk(input string req, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, exp);
    chk({req, " model"}, v, m_read(a));
  endtask

  task automatic rcnt(input string req, input int n, input logic [15:0] exp);
    rchk(req, 8'h68 + 8'(8*n) + 8'd2, exp[15:8]);
    rchk(req, 8'h68 + 8'(8*n) + 8'd3, exp[7:0]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd1234));
    for (int n = 0; n < NCH; n++) begin
      m_mode[n] = 0; m_cen[n] = 0; m_cnt[n] = 0; m_ca[n] = 0; m_cb[n] = 0;
    end
    for (int k = 0; k < 3; k++) m_st[k] = 0;
    m_run = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;

    // R1 reset state
    rchk("R1 run", 8'h60, 8'h00);
    rchk("R1 stat", 8'h65, 8'h00);
    rchk("R1 mode", 8'h68, 8'h00);
    rcnt("R1 count", 2, 16'h0000);
    chk("R1 irq", irq, '0);

    // R3 window layout readback
    wr16(8'h74, 16'hA5C3);
    rchk("R3 cmpA hi ch1", 8'h74, 8'hA5);
    rchk("R3 cmpA lo ch1", 8'h75, 8'hC3);
    rchk("R3 unmapped", 8'h90, 8'h00);

    // R2 counting gated by tick and run
    cyc(1'b0, 8'h00, 8'h00, 3'b001);
    rcnt("R2 no run", 0, 16'h0000);
    wr8(8'h60, 8'h01);
    for (int i = 0; i < 5; i++) cyc(1'b0, 8'h00, 8'h00, 3'b001);
    rcnt("R2 five ticks", 0, 16'h0005);
    cyc(1'b0, 8'h00, 8'h00, 3'b000);
    rcnt("R2 tick low", 0, 16'h0005);

    // R4/R5 ch1 clear on A at 3
    wr16(8'h74, 16'h0003);
    wr8(8'h71, 8'h01);
    wr8(8'h70, 8'h20);
    wr8(8'h60, 8'h03);
    for (int i = 0; i < 3; i++) cyc(1'b0, 8'h00, 8'h00, 3'b010);
    rcnt("R5 clear on A", 1, 16'h0000);
    rchk("R4 flag A ch1", 8'h64, 8'h02);
    rchk("R5 still running", 8'h60, 8'h03);
    cyc(1'b0, 8'h00, 8'h00, 3'b010);
    rcnt("R5 runs on", 1, 16'h0001);

    // R6 ch2 stops on B at 2 (no clear source)
    wr16(8'h7E, 16'h0002);
    wr8(8'h79, 8'h10);
    wr8(8'h60, 8'h07);
    for (int i = 0; i < 4; i++) cyc(1'b0, 8'h00, 8'h00, 3'b100);
    rcnt("R6 holds match", 2, 16'h0002);
    rchk("R6 run cleared", 8'h60, 8'h03);
    rchk("R4 flag B ch2", 8'h65, 8'h04);
    // R6 halt beats same-cycle run write
    wr16(8'h7A, 16'h0000);
    wr8(8'h60, 8'h07);
    wr16(8'h7E, 16'h0001);
    cyc(1'b1, 8'h60, 8'h07, 3'b100);
    rchk("R6 halt over write", 8'h60, 8'h03);

    // R7 wrap on ch0 with compares off
    wr16(8'h6A, 16'hFFFF);
    cyc(1'b0, 8'h00, 8'h00, 3'b001);
    rcnt("R7 wrap", 0, 16'h0000);
    rchk("R7 wrap flag", 8'h66, 8'h01);
    // R7 no wrap flag when a compare is active (ch1)
    wr16(8'h74, 16'h1234);
    wr16(8'h72, 16'hFFFF);
    cyc(1'b0, 8'h00, 8'h00, 3'b010);
    rchk("R7 gated by compare", 8'h66, 8'h01);

    // R8/R9 flag write-0-to-clear, enable, priority
    wr8(8'h66, 8'h17);
    rchk("R8 write 1 keeps", 8'h66, 8'h11);
    chk("R9 wrap irq ch0", irq[2], 1'b1);
    wr8(8'h66, 8'h10);
    rchk("R8 write 0 clears", 8'h66, 8'h10);
    chk("R9 irq drops", irq[2], 1'b0);
    wr16(8'h6A, 16'hFFFF);
    cyc(1'b1, 8'h66, 8'h10, 3'b001);
    rchk("R8 hw set wins", 8'h66, 8'h11);

    // R10 load beats tick
    cyc(1'b1, 8'h6B, 8'h40, 3'b001);
    rcnt("R10 load wins", 0, 16'h0040);

    // R11 compares inactive: equal value ignored
    wr8(8'h69, 8'h00);
    wr16(8'h6C, 16'h0041);
    cyc(1'b0, 8'h00, 8'h00, 3'b001);
    rcnt("R11 passes value", 0, 16'h0041);
    rchk("R11 still running", 8'h60, 8'h03);
    rchk("R11 no flag", 8'h64, 8'h02);

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      int sel;
      sel = $urandom_range(0, 9);
      if (sel < 6) cyc(1'b0, 8'h00, 8'h00, 3'($urandom));
      else if (sel < 9) begin
        logic [7:0] a, d;
        int pick;
        pick = $urandom_range(0, 9);
        if (pick == 0) a = 8'h60;
        else if (pick < 3) a = 8'h64 + 8'($urandom_range(0, 2));
        else a = 8'h68 + 8'($urandom_range(0, 8*NCH - 1));
        d = 8'($urandom);
        if (a >= 8'h68 && ((a - 8'h68) & 8'h1) == 0 && ((a - 8'h68) & 8'h6) != 0)
          d = ($urandom_range(0, 3) == 0) ? 8'hFF : 8'h00;
        if (a >= 8'h68 && (((a - 8'h68) & 8'h7) == 5 || ((a - 8'h68) & 8'h7) == 7))
          d = 8'($urandom_range(0, 15));
        cyc(1'b1, a, d, 3'($urandom));
      end else begin
        logic [7:0] a;
        a = 8'h60 + 8'($urandom_range(0, 8 + 8*NCH - 1));
        rd(a, v);
        chk("R3 random readback", v, m_read(a));
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule